// File: doc/BRIEF.md
# Descriptor Ring Status Writeback Engine

This engine sits on the DMA side of a network controller. It maintains two circular descriptor rings, one for receive and one for transmit, held in a 32-bit word-addressed memory. Each descriptor is four words long. Word 1 carries an ownership flag, status flags and the buffer size. Word 2 carries further status or the received byte count. The host hands a descriptor to the controller by setting the ownership flag. When a stub MAC reports a finished frame, the engine reads the current descriptor of that direction. If the controller owns it, the engine writes packed status back, returns the descriptor to the host, advances the ring index and raises a completion pulse. If the host owns it, the engine drops the event and raises a missed-frame pulse.

A start pulse latches both ring base addresses and both length bytes, and it rewinds both ring indices. A transmit-demand pulse makes the engine read the current transmit descriptor at once and report on `tx_ready` whether the controller owns it. The memory port has no handshake. A read returns its data in the cycle after the request.

Top module: `dre_writeback`

## Requirements
- R1: A `start` pulse latches `rx_base`, `tx_base`, `rx_len_cfg` and `tx_len_cfg`, sets both ring indices to 0 and clears `tx_ready`. Until the first `start`, frame events and demand pulses cause no memory access and no output pulse.
- R2: A ring base is taken with its two low bits forced to zero. Entry i of a ring begins at base + 4*i. Word 1 of an entry is md1 and word 2 is md2. The engine reads only md1.
- R3: Bit 31 of md1 is the ownership flag, where 1 means the controller owns the entry. The engine writes status only to an entry whose flag is 1, and every md1 it writes has bit 31 cleared.
- R4: A receive or transmit frame event that finds the current entry's bit 31 at 0 leaves md1 and md2 unchanged. It raises `missed` for one cycle and leaves the ring index where it was.
- R5: Receive md1 written: bit 29 = rx_err[3] (framing), bit 28 = rx_err[2] (overflow), bit 27 = rx_err[1] (CRC), bit 26 = rx_err[0] (buffer). Bit 30 is the OR of those four, bits 25 and 24 (start and end of packet) are set, and bits 23:0, which hold the negative buffer size, are kept.
- R6: Receive md2 written equals `rx_bytes` (the 12-bit count, CRC bytes included) in bits 11:0, with bits 31:12 at zero.
- R7: Transmit md1 written: bit 26 = tx_stat[0] (deferred), bit 27 = tx_stat[1] (one retry), bit 28 = tx_stat[2] (several retries). Bit 30 is the OR of tx_stat[6:3], and bit 29 and bits 25:0 are kept.
- R8: Transmit md2 written: bit 26 = tx_stat[3] (retry failure), bit 27 = tx_stat[4] (carrier lost), bit 28 = tx_stat[5] (late collision), bit 30 = tx_stat[6] (underflow), bit 31 = tx_stat[7] (buffer). All other bits are zero.
- R9: A completed entry raises `rx_irq` or `tx_irq` for one cycle, in the cycle after its md2 write. The index then advances modulo 2^N, where N is bits 7:4 of that ring's length byte. Bits 3:0 of the length byte are ignored.
- R10: A `tx_demand` pulse reads the current transmit md1 and sets `tx_ready` to its bit 31. It writes nothing, raises no pulse and moves no index.
- R11: When receive and transmit events are both pending, the receive event is served first, and both are served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load ring configuration and rewind indices |
| rx_base | input | AW | Receive ring base word address |
| tx_base | input | AW | Transmit ring base word address |
| rx_len_cfg | input | 8 | Receive ring log2 length in bits 7:4 |
| tx_len_cfg | input | 8 | Transmit ring log2 length in bits 7:4 |
| rx_done | input | 1 | Receive frame finished pulse |
| rx_err | input | 4 | Receive error flags {framing, overflow, CRC, buffer} |
| rx_bytes | input | 12 | Received byte count including CRC |
| tx_done | input | 1 | Transmit frame finished pulse |
| tx_stat | input | 8 | Transmit status {buf, uflo, lcol, lcar, rtry, more, one, def} |
| tx_demand | input | 1 | Poll current transmit descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read |
| rx_irq | output | 1 | Receive completion pulse |
| tx_irq | output | 1 | Transmit completion pulse |
| missed | output | 1 | Frame event dropped on a host-owned entry |
| tx_ready | output | 1 | Ownership flag seen by the last transmit poll |

## Verification
On every cycle the assertions check several properties. Every md1 write clears the ownership flag, and the receive summary bit agrees with the four error bits. A receive md2 write has a clean upper field. Reads target md1 only. Completion pulses follow an md2 write, a missed pulse never follows a write, the pulses are mutually exclusive, and the memory stays silent before start. Only the bench scenarios can show several other behaviours: that the field values match the MAC's inputs, that indices wrap at the configured length, that a restart rewinds them, that the receive side wins when both directions are pending, and that a poll reports ownership without touching memory.

// File: rtl/dre_pkg.sv
package dre_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_CHK  = 3'd2,
    ST_WR1  = 3'd3,
    ST_WR2  = 3'd4
  } dre_state_e;

  typedef enum logic [1:0] {
    KD_RX   = 2'd0,
    KD_TX   = 2'd1,
    KD_POLL = 2'd2
  } dre_kind_e;

  localparam int unsigned OWN_BIT = 31;
  localparam logic [1:0]  MD1_OFS = 2'd1;
  localparam logic [1:0]  MD2_OFS = 2'd2;
endpackage

// File: rtl/dre_rst_sync.sv
module dre_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/dre_ring_ptr.sv
module dre_ring_ptr #(
  parameter int IW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [3:0]    log2n,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] mask;
  logic [IW-1:0] idx_d;

  // all ones below bit log2n; saturates when log2n >= IW
  assign mask = ~({IW{1'b1}} << log2n);

  always_comb begin
    idx_d = idx;
    if (clr)      idx_d = '0;
    else if (adv) idx_d = (idx + 1'b1) & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else        idx <= idx_d;
  end
endmodule

// File: rtl/dre_status_fmt.sv
module dre_status_fmt #(
  parameter int LW = 12
) (
  input  logic          is_tx,
  input  logic [31:0]   md1_in,
  input  logic [3:0]    rx_err,
  input  logic [LW-1:0] rx_len,
  input  logic [7:0]    tx_stat,
  output logic [31:0]   md1_out,
  output logic [31:0]   md2_out
);
  always_comb begin
    if (is_tx) begin
      md1_out = {1'b0, |tx_stat[6:3], md1_in[29], tx_stat[2:0], md1_in[25:0]};
      md2_out = {tx_stat[7], tx_stat[6], 1'b0, tx_stat[5], tx_stat[4],
                 tx_stat[3], 26'd0};
    end else begin
      md1_out = {1'b0, |rx_err, rx_err, 2'b11, md1_in[23:0]};
      md2_out = {{(32-LW){1'b0}}, rx_len};
    end
  end
endmodule

// File: rtl/dre_writeback.sv
module dre_writeback #(
  parameter int AW      = 20,
  parameter int MAX_LOG = 15,
  parameter int LW      = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] rx_base,
  input  logic [AW-1:0] tx_base,
  input  logic [7:0]    rx_len_cfg,
  input  logic [7:0]    tx_len_cfg,
  input  logic          rx_done,
  input  logic [3:0]    rx_err,
  input  logic [LW-1:0] rx_bytes,
  input  logic          tx_done,
  input  logic [7:0]    tx_stat,
  input  logic          tx_demand,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          rx_irq,
  output logic          tx_irq,
  output logic          missed,
  output logic          tx_ready
);
  import dre_pkg::*;

  localparam int IW = MAX_LOG;

  logic rst_i_n;
  dre_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  // configuration and state
  logic          running_q;
  logic [AW-1:0] rx_base_q, tx_base_q;
  logic [3:0]    rx_log_q, tx_log_q;
  logic          rx_pend_q, tx_pend_q, poll_pend_q;
  logic          rx_pend_d, tx_pend_d, poll_pend_d;
  logic [3:0]    rx_err_q, wk_err_q;
  logic [LW-1:0] rx_len_q, wk_len_q;
  logic [7:0]    tx_stat_q, wk_stat_q;
  dre_state_e    state_q, state_d;
  dre_kind_e     kind_q, kind_d;
  logic [31:0]   md1_q;
  logic          rx_irq_q, tx_irq_q, miss_q, tx_rdy_q;
  logic          rx_irq_d, tx_irq_d, miss_d, tx_rdy_d;
  logic          take_rx, take_tx, take_poll, take_any;
  logic          adv_rx, adv_tx;
  logic [IW-1:0] rx_idx, tx_idx, cur_idx;
  logic [AW-1:0] cur_base, desc_addr;
  logic [31:0]   md1_w, md2_w;

  dre_ring_ptr #(.IW(IW)) u_rx_ptr (
    .clk(clk), .rst_n(rst_i_n), .clr(start), .adv(adv_rx),
    .log2n(rx_log_q), .idx(rx_idx));

  dre_ring_ptr #(.IW(IW)) u_tx_ptr (
    .clk(clk), .rst_n(rst_i_n), .clr(start), .adv(adv_tx),
    .log2n(tx_log_q), .idx(tx_idx));

  dre_status_fmt #(.LW(LW)) u_fmt (
    .is_tx(kind_q != KD_RX), .md1_in(md1_q), .rx_err(wk_err_q),
    .rx_len(wk_len_q), .tx_stat(wk_stat_q), .md1_out(md1_w), .md2_out(md2_w));

  // descriptor addressing
  assign cur_idx   = (kind_q == KD_RX) ? rx_idx : tx_idx;
  assign cur_base  = (kind_q == KD_RX) ? rx_base_q : tx_base_q;
  assign desc_addr = {cur_base[AW-1:2], 2'b00} + AW'({cur_idx, 2'b00});

  assign mem_req   = (state_q == ST_RD) || (state_q == ST_WR1) || (state_q == ST_WR2);
  assign mem_we    = (state_q == ST_WR1) || (state_q == ST_WR2);
  assign mem_addr  = desc_addr + AW'((state_q == ST_WR2) ? MD2_OFS : MD1_OFS);
  assign mem_wdata = (state_q == ST_WR2) ? md2_w : md1_w;

  assign rx_irq   = rx_irq_q;
  assign tx_irq   = tx_irq_q;
  assign missed   = miss_q;
  assign tx_ready = tx_rdy_q;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    rx_irq_d  = 1'b0;
    tx_irq_d  = 1'b0;
    miss_d    = 1'b0;
    tx_rdy_d  = tx_rdy_q;
    take_rx   = 1'b0;
    take_tx   = 1'b0;
    take_poll = 1'b0;
    adv_rx    = 1'b0;
    adv_tx    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (running_q) begin
          if (rx_pend_q) begin
            take_rx = 1'b1; kind_d = KD_RX; state_d = ST_RD;
          end else if (tx_pend_q) begin
            take_tx = 1'b1; kind_d = KD_TX; state_d = ST_RD;
          end else if (poll_pend_q) begin
            take_poll = 1'b1; kind_d = KD_POLL; state_d = ST_RD;
          end
        end
      end
      ST_RD:  state_d = ST_CHK;
      ST_CHK: begin
        if (kind_q == KD_POLL) begin
          tx_rdy_d = mem_rdata[OWN_BIT];
          state_d  = ST_IDLE;
        end else if (!mem_rdata[OWN_BIT]) begin
          miss_d  = 1'b1;
          state_d = ST_IDLE;
          if (kind_q == KD_TX) tx_rdy_d = 1'b0;
        end else begin
          state_d = ST_WR1;
        end
      end
      ST_WR1: state_d = ST_WR2;
      ST_WR2: begin
        state_d = ST_IDLE;
        if (kind_q == KD_RX) begin
          rx_irq_d = 1'b1; adv_rx = 1'b1;
        end else begin
          tx_irq_d = 1'b1; adv_tx = 1'b1; tx_rdy_d = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (start) begin
      state_d  = ST_IDLE;
      tx_rdy_d = 1'b0;
      adv_rx   = 1'b0;
      adv_tx   = 1'b0;
    end
  end

  assign take_any    = take_rx | take_tx | take_poll;
  assign rx_pend_d   = !start && ((running_q && rx_done) || (rx_pend_q && !take_rx));
  assign tx_pend_d   = !start && ((running_q && tx_done) || (tx_pend_q && !take_tx));
  assign poll_pend_d = !start && ((running_q && tx_demand) || (poll_pend_q && !take_poll));

  // control registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q     <= ST_IDLE;
      kind_q      <= KD_RX;
      running_q   <= 1'b0;
      rx_pend_q   <= 1'b0;
      tx_pend_q   <= 1'b0;
      poll_pend_q <= 1'b0;
      rx_irq_q    <= 1'b0;
      tx_irq_q    <= 1'b0;
      miss_q      <= 1'b0;
      tx_rdy_q    <= 1'b0;
    end else begin
      state_q     <= state_d;
      kind_q      <= kind_d;
      running_q   <= running_q | start;
      rx_pend_q   <= rx_pend_d;
      tx_pend_q   <= tx_pend_d;
      poll_pend_q <= poll_pend_d;
      rx_irq_q    <= rx_irq_d;
      tx_irq_q    <= tx_irq_d;
      miss_q      <= miss_d;
      tx_rdy_q    <= tx_rdy_d;
    end
  end

  // data registers with explicit enables
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rx_base_q <= '0;
      tx_base_q <= '0;
      rx_log_q  <= '0;
      tx_log_q  <= '0;
      rx_err_q  <= '0;
      rx_len_q  <= '0;
      tx_stat_q <= '0;
      wk_err_q  <= '0;
      wk_len_q  <= '0;
      wk_stat_q <= '0;
      md1_q     <= '0;
    end else begin
      if (start) begin
        rx_base_q <= rx_base;
        tx_base_q <= tx_base;
        rx_log_q  <= rx_len_cfg[7:4];
        tx_log_q  <= tx_len_cfg[7:4];
      end
      if (rx_done) begin
        rx_err_q <= rx_err;
        rx_len_q <= rx_bytes;
      end
      if (tx_done) tx_stat_q <= tx_stat;
      if (take_any) begin
        wk_err_q  <= rx_err_q;
        wk_len_q  <= rx_len_q;
        wk_stat_q <= tx_stat_q;
      end
      if (state_q == ST_CHK) md1_q <= mem_rdata;
    end
  end
endmodule

// File: rtl/dre_writeback_chk.sv
module dre_writeback_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          running,
  input logic          is_rx,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          rx_irq,
  input logic          tx_irq,
  input logic          missed
);
  p_own_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr[1:0] == 2'd1) |-> !mem_wdata[31]);

  p_rx_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && is_rx && mem_addr[1:0] == 2'd1)
      |-> (mem_wdata[30] == |mem_wdata[29:26]));

  p_rx_count_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && is_rx && mem_addr[1:0] == 2'd2)
      |-> (mem_wdata[31:12] == 20'd0));

  p_read_md1_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[1:0] == 2'd1));

  p_irq_after_md2_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq || tx_irq) |-> $past(mem_req && mem_we && mem_addr[1:0] == 2'd2));

  p_miss_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    missed |-> !$past(mem_req && mem_we));

  p_pulses_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_irq, tx_irq, missed}));

  p_quiet_before_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !mem_req);
endmodule

bind dre_writeback dre_writeback_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .running(running_q),
  .is_rx(kind_q == dre_pkg::KD_RX), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rx_irq(rx_irq),
  .tx_irq(tx_irq), .missed(missed));

// File: tb/dre_writeback_tb_top.sv
module dre_writeback_tb_top;
  localparam int AW  = 20;
  localparam int RXB = 'h40;
  localparam int TXB = 'h80;
  localparam int RXN = 4;
  localparam int TXN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] rx_base = '0, tx_base = '0;
  logic [7:0] rx_len_cfg = '0, tx_len_cfg = '0;
  logic rx_done = 1'b0, tx_done = 1'b0, tx_demand = 1'b0;
  logic [3:0] rx_err = '0;
  logic [11:0] rx_bytes = '0;
  logic [7:0] tx_stat = '0;
  logic mem_req, mem_we, rx_irq, tx_irq, missed, tx_ready;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic h_we = 1'b0;
  int   h_addr = 0;
  logic [31:0] h_wdata = '0;
  logic [31:0] mem [0:255];

  int nchk = 0, nerr = 0;
  int n_rx = 0, n_tx = 0, n_miss = 0, n_wr = 0, n_acc = 0, cyc = 0;
  int rx_cyc = 0, tx_cyc = 0;
  int erx = 0, etx = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dre_writeback #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_base(rx_base), .tx_base(tx_base),
    .rx_len_cfg(rx_len_cfg), .tx_len_cfg(tx_len_cfg), .rx_done(rx_done),
    .rx_err(rx_err), .rx_bytes(rx_bytes), .tx_done(tx_done), .tx_stat(tx_stat),
    .tx_demand(tx_demand), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rx_irq(rx_irq), .tx_irq(tx_irq),
    .missed(missed), .tx_ready(tx_ready));

  // memory model: one-cycle read latency, host side write port
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'd0;
      mem_rdata <= 32'd0;
    end else begin
      if (mem_req) n_acc = n_acc + 1;
      if (mem_req && mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        n_wr = n_wr + 1;
      end else if (h_we) begin
        mem[h_addr[7:0]] <= h_wdata;
      end
      if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
      if (rx_irq) begin n_rx = n_rx + 1; rx_cyc = cyc; end
      if (tx_irq) begin n_tx = n_tx + 1; tx_cyc = cyc; end
      if (missed) n_miss = n_miss + 1;
    end
  end

  function automatic logic [31:0] exp_rx_md1(logic [31:0] o, logic [3:0] e);
    return {1'b0, |e, e, 2'b11, o[23:0]};
  endfunction
  function automatic logic [31:0] exp_rx_md2(logic [11:0] l);
    return {20'd0, l};
  endfunction
  function automatic logic [31:0] exp_tx_md1(logic [31:0] o, logic [7:0] s);
    return {1'b0, |s[6:3], o[29], s[2], s[1], s[0], o[25:0]};
  endfunction
  function automatic logic [31:0] exp_tx_md2(logic [7:0] s);
    return {s[7], s[6], 1'b0, s[5], s[4], s[3], 26'd0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    h_we = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    erx = 0; etx = 0;
  endtask

  task automatic step_rx(input bit own, input logic [3:0] e, input logic [11:0] l);
    int a, s_rx, s_miss;
    logic [31:0] o1, o2;
    a  = RXB + 4 * erx;
    o1 = {own, 7'd0, 8'($urandom), 16'hFA0E};
    o2 = $urandom;
    host_wr(a + 1, o1);
    host_wr(a + 2, o2);
    s_rx = n_rx; s_miss = n_miss;
    @(negedge clk);
    rx_done = 1'b1; rx_err = e; rx_bytes = l;
    @(negedge clk);
    rx_done = 1'b0; rx_err = $urandom; rx_bytes = $urandom;
    idle(12);
    if (own) begin
      chk(mem[a + 1] == exp_rx_md1(o1, e), "R5 rx md1", mem[a + 1], exp_rx_md1(o1, e));
      chk(mem[a + 2] == exp_rx_md2(l), "R6 rx md2", mem[a + 2], exp_rx_md2(l));
      chk(n_rx == s_rx + 1, "R9 rx_irq count", n_rx, s_rx + 1);
      erx = (erx + 1) % RXN;
    end else begin
      chk(mem[a + 1] == o1 && mem[a + 2] == o2, "R4 rx host-owned untouched",
          mem[a + 1], o1);
      chk(n_miss == s_miss + 1 && n_rx == s_rx, "R4 rx missed pulse", n_miss, s_miss + 1);
    end
  endtask

  task automatic step_tx(input bit own, input logic [7:0] s);
    int a, s_tx, s_miss;
    logic [31:0] o1, o2;
    a  = TXB + 4 * etx;
    o1 = {own, 1'b0, 1'($urandom), 3'b000, 2'b11, 8'($urandom), 16'hFF00};
    o2 = $urandom;
    host_wr(a + 1, o1);
    host_wr(a + 2, o2);
    s_tx = n_tx; s_miss = n_miss;
    @(negedge clk);
    tx_done = 1'b1; tx_stat = s;
    @(negedge clk);
    tx_done = 1'b0; tx_stat = $urandom;
    idle(12);
    if (own) begin
      chk(mem[a + 1] == exp_tx_md1(o1, s), "R7 tx md1", mem[a + 1], exp_tx_md1(o1, s));
      chk(mem[a + 2] == exp_tx_md2(s), "R8 tx md2", mem[a + 2], exp_tx_md2(s));
      chk(n_tx == s_tx + 1, "R9 tx_irq count", n_tx, s_tx + 1);
      etx = (etx + 1) % TXN;
    end else begin
      chk(mem[a + 1] == o1 && mem[a + 2] == o2, "R4 tx host-owned untouched",
          mem[a + 1], o1);
      chk(n_miss == s_miss + 1 && n_tx == s_tx, "R4 tx missed pulse", n_miss, s_miss + 1);
    end
  endtask

  task automatic step_poll(input bit own);
    int a, s_w, s_p;
    logic [31:0] o1;
    a  = TXB + 4 * etx;
    o1 = {own, 15'd0, 16'hFF40};
    host_wr(a + 1, o1);
    s_w = n_wr; s_p = n_rx + n_tx + n_miss;
    @(negedge clk);
    tx_demand = 1'b1;
    @(negedge clk);
    tx_demand = 1'b0;
    idle(10);
    chk(tx_ready == own, "R10 tx_ready after poll", tx_ready, own);
    chk(n_wr == s_w && n_rx + n_tx + n_miss == s_p, "R10 poll writes and pulses",
        n_wr, s_w);
  endtask

  initial begin
    void'($urandom(32'd4711));
    idle(3);
    chk(mem_req == 1'b0 && rx_irq == 1'b0 && tx_ready == 1'b0, "R1 reset outputs",
        {mem_req, rx_irq, tx_ready}, 0);
    rst_n = 1'b1;
    idle(4);

    // events before the first start are ignored
    @(negedge clk);
    rx_done = 1'b1; tx_done = 1'b1; tx_demand = 1'b1;
    @(negedge clk);
    rx_done = 1'b0; tx_done = 1'b0; tx_demand = 1'b0;
    idle(12);
    chk(n_acc == 0 && n_miss == 0 && n_rx == 0, "R1 no activity before start", n_acc, 0);

    // configure: low base bits and low length nibble must be ignored (R2, R9)
    rx_base = AW'(RXB + 3); tx_base = AW'(TXB + 1);
    rx_len_cfg = 8'h2B; tx_len_cfg = 8'h37;
    do_start();

    step_rx(1'b1, 4'b0000, 12'd64);
    step_rx(1'b1, 4'b1010, 12'd1518);
    step_rx(1'b0, 4'b0001, 12'd99);
    step_tx(1'b1, 8'b0000_0000);
    step_tx(1'b1, 8'b1010_1010);
    step_tx(1'b0, 8'hFF);
    step_poll(1'b1);
    step_poll(1'b0);

    // ring wrap: rx has 4 entries, two used so far
    step_rx(1'b1, 4'b0100, 12'd100);
    step_rx(1'b1, 4'b0000, 12'd200);
    chk(erx == 0, "R9 rx model wrapped", erx, 0);
    step_rx(1'b1, 4'b1111, 12'd4095);

    // both directions pending together: receive served first (R11)
    begin
      int ar, at;
      logic [31:0] r1, t1;
      ar = RXB + 4 * erx; at = TXB + 4 * etx;
      r1 = 32'h8000_FA00; t1 = 32'h8300_FF00;
      host_wr(ar + 1, r1);
      host_wr(at + 1, t1);
      @(negedge clk);
      rx_done = 1'b1; rx_err = 4'b0010; rx_bytes = 12'd77;
      tx_done = 1'b1; tx_stat = 8'b0100_0001;
      @(negedge clk);
      rx_done = 1'b0; tx_done = 1'b0;
      idle(20);
      chk(rx_cyc < tx_cyc, "R11 rx before tx", rx_cyc, tx_cyc);
      chk(mem[ar + 1] == exp_rx_md1(r1, 4'b0010), "R11 rx served", mem[ar + 1],
          exp_rx_md1(r1, 4'b0010));
      chk(mem[at + 2] == exp_tx_md2(8'b0100_0001), "R11 tx served", mem[at + 2],
          exp_tx_md2(8'b0100_0001));
      erx = (erx + 1) % RXN; etx = (etx + 1) % TXN;
    end

    // constrained random mix
    for (int it = 0; it < 90; it++) begin
      int op;
      bit own;
      op  = $urandom % 3;
      own = ($urandom % 4) != 0;
      case (op)
        0: step_rx(own, ($urandom % 2) ? 4'($urandom) : 4'd0, 12'($urandom));
        1: step_tx(own, ($urandom % 2) ? 8'($urandom) : 8'($urandom % 8));
        default: step_poll(own);
      endcase
    end

    // restart rewinds indices and clears tx_ready (R1)
    step_poll(1'b1);
    do_start();
    idle(2);
    chk(tx_ready == 1'b0, "R1 start clears tx_ready", tx_ready, 0);
    step_rx(1'b1, 4'b0001, 12'd60);
    chk(mem[RXB + 2] == 32'd60, "R1 restart uses rx entry 0", mem[RXB + 2], 32'd60);
    step_tx(1'b1, 8'h08);
    chk(mem[TXB + 2] == exp_tx_md2(8'h08), "R1 restart uses tx entry 0", mem[TXB + 2],
        exp_tx_md2(8'h08));

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule